// File: doc/BRIEF.md
# Split-Read Clear-on-Read Event Counter

This block counts event pulses, for example frames dropped or cut short by a buffer that ran full. The count is 36 bits wide, but software sees it through a 32-bit read port. It reads the count as two words in a fixed order: first the low word, then the high word. Whatever produces the events lives outside this block and simply pulses the increment input for one cycle per event.

A read of the low word does three things at once:

- it returns the live count's low bits;
- it stores the live count's upper bits in a snapshot;
- it restarts the live count.

The later read of the high word returns that snapshot, so the two halves always belong to the same instant. Events keep being counted between the two reads. An event that lands in the same cycle as the low-word read is kept. The count stops at all ones instead of wrapping.

Read data is registered. It appears on the port in the cycle after the strobe and is zero in every other cycle.

Top module: `evtcnt_split_rd`

## Requirements
- R1: After a synchronous active-low reset, the live count, the snapshot and the read data are all zero.
- R2: Each cycle with the increment input high and no low-word read raises the live count by exactly one. The count is unchanged when the increment input is low.
- R3: A strobe with word select 0 (low word) puts bits [31:0] of the live count, as it was before that edge, on the read data one cycle later.
- R4: A low-word read restarts the live count. It goes to 0, or to 1 if the increment input is high in the same cycle, so that event is not lost.
- R5: A strobe with word select 1 (high word) puts count bits [35:32], as captured by the most recent low-word read, in read data bits [3:0] one cycle later. Bits [31:4] of that word are zero, and events arriving after the low-word read do not change it.
- R6: A high-word read neither clears nor changes the live count or the snapshot. Repeated high-word reads return the same value.
- R7: With the live count at all ones, further events leave it at all ones.
- R8: In any cycle that does not follow a read strobe, the read data is zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| evt_i | input | 1 | One-cycle event pulse; each high cycle counts one event |
| rd_stb_i | input | 1 | Register read strobe, one cycle per read |
| rd_addr_i | input | 1 | Word select: 0 low word, 1 high word |
| rd_data_o | output | 32 | Read data, valid the cycle after the strobe |

## Verification
The assertions check the following on every cycle:

- the live count's step rules: increment, hold, restart on a low-word read and stick at all ones;
- that a high-word read leaves the snapshot untouched;
- the returned low word;
- the zero fill of the high word;
- the zero idle data.

Only the bench's scenarios can show the two-word order working end to end:

- a high word that stays coherent while events keep arriving after the low read;
- an event coinciding with the clearing read;
- saturation.

Saturation cannot be reached at 36 bits in a bench. It is therefore shown on a second, narrow instance, which also shows the carry into the high word.

// File: rtl/evtcnt_pkg.sv
// Shared types for the split-read event counter.
// Assumes a single-bit word select on the read port.
package evtcnt_pkg;

    // Word select encoding of the read address
    typedef enum logic {
        WSEL_LO = 1'b0,
        WSEL_HI = 1'b1
    } wsel_e;

endpackage

// File: rtl/evtcnt_acc.sv
// Saturating live event accumulator with clear-and-load.
// A clear loads 1 when an event coincides with it, else 0.
// Assumes inc_i is at most one event per cycle.
module evtcnt_acc #(
    parameter int CNT_W = 36
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc_i,
    input  logic             clr_i,
    output logic [CNT_W-1:0] cnt_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_q;

    // Count events, restart on clear, stop at all ones
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr_i) begin
            cnt_q <= inc_i ? CNT_ONE : '0;
        end else if (inc_i && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + CNT_ONE;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/evtcnt_snap.sv
// Snapshot of the count bits above the bus width.
// Loaded on a low-word read; held otherwise.
module evtcnt_snap #(
    parameter int HI_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cap_i,
    input  logic [HI_W-1:0] d_i,
    output logic [HI_W-1:0] q_o
);
    logic [HI_W-1:0] q_q;

    // Capture upper count bits when a low-word read occurs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else if (cap_i) begin
            q_q <= d_i;
        end
    end

    assign q_o = q_q;
endmodule

// File: rtl/evtcnt_rdport.sv
// Registered read data path: low word from the live count,
// high word from the snapshot, zero-filled. Zero when no read.
// Assumes 0 < HI_W <= BUS_W.
module evtcnt_rdport #(
    parameter int BUS_W = 32,
    parameter int HI_W  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb_i,
    input  logic             sel_hi_i,
    input  logic [BUS_W-1:0] live_lo_i,
    input  logic [HI_W-1:0]  snap_hi_i,
    output logic [BUS_W-1:0] data_o
);
    logic [BUS_W-1:0] hi_word;
    logic [BUS_W-1:0] data_q;

    // Zero-extend the snapshot to the bus width when it is narrower
    generate
        if (HI_W < BUS_W) begin : g_pad
            assign hi_word = {{(BUS_W-HI_W){1'b0}}, snap_hi_i};
        end else begin : g_full
            assign hi_word = snap_hi_i;
        end
    endgenerate

    // Register the selected word for one cycle after a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (stb_i) begin
            data_q <= sel_hi_i ? hi_word : live_lo_i;
        end else begin
            data_q <= '0;
        end
    end

    assign data_o = data_q;
endmodule

// File: rtl/evtcnt_split_rd.sv
// Top: event counter read as two words, low first then high.
// Low-word read returns live low bits, snapshots upper bits and
// restarts the count in the same cycle.
// Assumes BUS_W < CNT_W <= 2*BUS_W.
module evtcnt_split_rd #(
    parameter int CNT_W = 36,
    parameter int BUS_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_i,
    input  logic             rd_stb_i,
    input  logic             rd_addr_i,
    output logic [BUS_W-1:0] rd_data_o
);
    import evtcnt_pkg::*;

    localparam int HI_W = CNT_W - BUS_W;

    wsel_e            wsel;
    logic             rd_lo;
    logic             rd_hi;
    logic [CNT_W-1:0] cnt_q;
    logic [HI_W-1:0]  snap_q;

    // Decode the read strobe into low-word and high-word reads
    always_comb begin
        wsel  = wsel_e'(rd_addr_i);
        rd_lo = rd_stb_i && (wsel == WSEL_LO);
        rd_hi = rd_stb_i && (wsel == WSEL_HI);
    end

    evtcnt_acc #(
        .CNT_W (CNT_W)
    ) u_acc (
        .clk   (clk),
        .rst_n (rst_n),
        .inc_i (evt_i),
        .clr_i (rd_lo),
        .cnt_o (cnt_q)
    );

    evtcnt_snap #(
        .HI_W (HI_W)
    ) u_snap (
        .clk   (clk),
        .rst_n (rst_n),
        .cap_i (rd_lo),
        .d_i   (cnt_q[CNT_W-1:BUS_W]),
        .q_o   (snap_q)
    );

    evtcnt_rdport #(
        .BUS_W (BUS_W),
        .HI_W  (HI_W)
    ) u_rd (
        .clk       (clk),
        .rst_n     (rst_n),
        .stb_i     (rd_stb_i),
        .sel_hi_i  (rd_hi),
        .live_lo_i (cnt_q[BUS_W-1:0]),
        .snap_hi_i (snap_q),
        .data_o    (rd_data_o)
    );
endmodule

// File: rtl/evtcnt_split_rd_chk.sv
// Checker for evtcnt_split_rd: count step rules, snapshot hold,
// read data contents. Bound to every instance of the top.
module evtcnt_split_rd_chk #(
    parameter int CNT_W = 36,
    parameter int BUS_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     evt_i,
    input logic                     rd_stb_i,
    input logic                     rd_addr_i,
    input logic [BUS_W-1:0]         rd_data_o,
    input logic [CNT_W-1:0]         cnt_q,
    input logic [CNT_W-BUS_W-1:0]   snap_q
);
    localparam int HI_W = CNT_W - BUS_W;
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic rd_lo;
    logic rd_hi;
    assign rd_lo = rd_stb_i && !rd_addr_i;
    assign rd_hi = rd_stb_i && rd_addr_i;

    AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && evt_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1); // R2
    AST_NO_EVT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && !evt_i) |=> $stable(cnt_q)); // R2
    AST_LO_WORD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> rd_data_o == $past(cnt_q[BUS_W-1:0])); // R3
    AST_CLR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lo |=> cnt_q == CNT_W'($past(evt_i))); // R4
    AST_HI_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> (rd_data_o >> HI_W) == '0); // R5
    AST_HI_SNAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi |=> $stable(snap_q)); // R6
    AST_SAT_STICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_lo && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX); // R7
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb_i |=> rd_data_o == '0); // R8
endmodule

bind evtcnt_split_rd evtcnt_split_rd_chk #(
    .CNT_W (CNT_W),
    .BUS_W (BUS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .evt_i     (evt_i),
    .rd_stb_i  (rd_stb_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .cnt_q     (cnt_q),
    .snap_q    (snap_q)
);

// File: tb/evtcnt_split_rd_test.sv
module evtcnt_split_rd_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        evt = 1'b0, stb = 1'b0, addr = 1'b0;
    logic [31:0] rdata;
    logic        s_evt = 1'b0, s_stb = 1'b0, s_addr = 1'b0;
    logic [3:0]  s_rdata;
    int          checks = 0;
    int          errors = 0;
    logic [31:0] got;

    always #10 clk = ~clk; // 50 MHz

    evtcnt_split_rd uut (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .rd_stb_i(stb),
        .rd_addr_i(addr), .rd_data_o(rdata)
    );

    // Narrow instance: 6-bit count, 4-bit bus, for saturation and carry
    evtcnt_split_rd #(.CNT_W(6), .BUS_W(4)) uut_small (
        .clk(clk), .rst_n(rst_n), .evt_i(s_evt), .rd_stb_i(s_stb),
        .rd_addr_i(s_addr), .rd_data_o(s_rdata)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic events(input int n);
        for (int i = 0; i < n; i++) begin
            evt = 1'b1;
            @(negedge clk);
        end
        evt = 1'b0;
    endtask

    task automatic s_events(input int n);
        for (int i = 0; i < n; i++) begin
            s_evt = 1'b1;
            @(negedge clk);
        end
        s_evt = 1'b0;
    endtask

    task automatic rd(input logic a, output logic [31:0] d);
        stb = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        stb = 1'b0; addr = 1'b0;
    endtask

    task automatic s_rd(input logic a, output logic [31:0] d);
        s_stb = 1'b1; s_addr = a;
        @(negedge clk);
        d = {28'd0, s_rdata};
        s_stb = 1'b0; s_addr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reset data", rdata, 32'd0);
        rd(1'b0, got); check("R1 reset low word", got, 32'd0);
        rd(1'b1, got); check("R1 reset high word", got, 32'd0);
        @(negedge clk); check("R8 idle data zero", rdata, 32'd0);
    endtask

    task automatic t_count();
        events(5);
        rd(1'b0, got); check("R2 R3 low word after 5 events", got, 32'd5);
        @(negedge clk); check("R8 data zero after read", rdata, 32'd0);
        rd(1'b1, got); check("R5 high word zero", got, 32'd0);
        rd(1'b0, got); check("R4 cleared by low read", got, 32'd0);
    endtask

    task automatic t_same_cycle();
        events(3);
        evt = 1'b1; stb = 1'b1; addr = 1'b0;
        @(negedge clk);
        got = rdata;
        evt = 1'b0; stb = 1'b0;
        check("R4 R3 read with coincident event", got, 32'd3);
        rd(1'b0, got); check("R4 coincident event kept", got, 32'd1);
    endtask

    task automatic t_hi_no_clear();
        events(7);
        rd(1'b1, got); check("R6 high read value", got, 32'd0);
        rd(1'b1, got); check("R6 repeated high read", got, 32'd0);
        rd(1'b0, got); check("R6 high read did not clear", got, 32'd7);
    endtask

    task automatic t_small_carry();
        s_events(20);
        s_rd(1'b0, got); check("R3 narrow low word", got, 32'd4);
        s_events(5);
        s_rd(1'b1, got); check("R5 narrow high from snapshot", got, 32'd1);
        s_rd(1'b1, got); check("R6 narrow high repeated", got, 32'd1);
        s_rd(1'b0, got); check("R2 narrow events after snapshot", got, 32'd5);
    endtask

    task automatic t_small_sat();
        s_events(70);
        s_rd(1'b0, got); check("R7 saturated low bits", got, 32'd15);
        s_rd(1'b1, got); check("R7 R5 saturated high bits", got, 32'd3);
        s_rd(1'b0, got); check("R4 cleared after saturation", got, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_same_cycle();
        t_hi_no_clear();
        t_small_carry();
        t_small_sat();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #2000000;
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule